// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable behavioral model of a 32-bit synchronous pipelined static RAM split into four byte lanes. It lets a design carry a clocked external-style memory on chip or stand in for one in simulation. Every control and data input is taken on the rising clock edge. A low address strobe either opens a new access at the presented address or deselects the device, depending on chip select. Cycles with the strobe high continue at the address already held. Read data leaves through an output register, and the bus-drive enable depends on that register, on the output enable and on the sleep input. The last two act without waiting for a clock edge.

The data bus is split into a write-data input, a read-data output and a drive flag (`drive_o`) that tells the surrounding logic when the model would be driving the bus. The array is built from one memory per byte lane, each written with a simple byte enable, so that block RAM can be inferred.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `drive_o` is low.
- R2: An edge with `strobe_n_i` low and `ce_n_i` low stores `addr_i` as the held address and starts an access at that address.
- R3: An edge with `strobe_n_i` low and `ce_n_i` high deselects the device. No access takes place, and later strobe-high edges perform no access and do not drive the bus until the next start.
- R4: An edge with `strobe_n_i` high, after a start and before any deselect, repeats the access at the held address. `addr_i` and `ce_n_i` are ignored on that edge.
- R5: An access is a write only when `wr_n_i` is low and at least one bit of `lane_n_i` is low. Otherwise it is a read and leaves the array unchanged.
- R6: Lane bit i of `lane_n_i` (active low) governs data bits 8i+7..8i. A write changes only the enabled lanes of the addressed word.
- R7: Read data appears on `rdata_o`, with `drive_o` high, after the clock edge that follows the edge starting the access. A write access never raises `drive_o`.
- R8: When `oe_n_i` is high, `drive_o` is low. The change takes effect at once, without a clock edge.
- R9: While `sleep_i` is high, no read or write reaches the array and `drive_o` is low at once.
- R10: The write data that is stored is the `wdata_i` value present on the same edge as the access it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (8) | Word address, taken on a start edge |
| ce_n_i | input | 1 | Chip select, active low, used only with the strobe low |
| strobe_n_i | input | 1 | Address strobe, active low |
| lane_n_i | input | LANES (4) | Per-byte write enables, active low |
| wr_n_i | input | 1 | Global write enable, active low |
| wdata_i | input | DATA_W (32) | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Standby, active high |
| rdata_o | output | DATA_W (32) | Registered read data |
| drive_o | output | 1 | High while the model drives the data bus |

## Verification
The bound checker watches the bus-drive rules on every cycle. These are the immediate gating by output enable and by sleep, a deselect edge never leading to a driven bus, the two-edge read latency, a write never driving the bus, and a suspended read holding its data word. Whether the array contents are right can only be shown by the bench's scenarios. These are a full write-then-read sweep, all sixteen lane-enable patterns, write decodes that fall back to reads, suspended writes that merge a lane into the held word, writes attempted while deselected or asleep, and write data changing right after its edge, all compared against a reference array kept in the bench.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CYC_NONE     = 2'd0,
    CYC_DESELECT = 2'd1,
    CYC_START    = 2'd2,
    CYC_SUSPEND  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strobe_n,
  input  logic             ce_n,
  input  logic             sleep,
  input  logic             active,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  output cyc_e             cyc,
  output logic             do_access,
  output logic             do_write
);
  always_comb begin
    if (sleep)          cyc = CYC_NONE;
    else if (!strobe_n) cyc = ce_n ? CYC_DESELECT : CYC_START;
    else                cyc = active ? CYC_SUSPEND : CYC_NONE;
  end

  assign do_access = (cyc == CYC_START) || (cyc == CYC_SUSPEND);
  assign do_write  = do_access && !wr_n && !(&lane_n);
endmodule

// File: rtl/sram_req_stage.sv
module sram_req_stage
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic              do_access,
  input  logic              do_write,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_n,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              active_o,
  output logic              req_vld_o,
  output logic              req_wr_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LANES-1:0]  req_be_o,
  output logic [DATA_W-1:0] req_data_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o  <= 1'b0;
      req_vld_o <= 1'b0;
      req_wr_o  <= 1'b0;
    end else begin
      if (cyc == CYC_START)         active_o <= 1'b1;
      else if (cyc == CYC_DESELECT) active_o <= 1'b0;
      req_vld_o <= do_access;
      req_wr_o  <= do_write;
    end
  end

  // Datapath registers carry no reset so they map onto plain flops.
  always_ff @(posedge clk) begin
    if (cyc == CYC_START) addr_q <= addr_i;
    req_be_o   <= ~lane_n;
    req_data_o <= wdata_i;
  end

  assign req_addr_o = addr_q;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en && wr && be[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (en && !wr)         rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= en && !wr;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              strobe_n_i,
  input  logic [LANES-1:0]  lane_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  cyc_e              cyc;
  logic              do_access, do_write, active;
  logic              req_vld, req_wr, rvalid;
  logic [ADDR_W-1:0] req_addr;
  logic [LANES-1:0]  req_be;
  logic [DATA_W-1:0] req_data;

  sram_cycle_decode #(.LANES(LANES)) u_decode (
    .strobe_n (strobe_n_i),
    .ce_n     (ce_n_i),
    .sleep    (sleep_i),
    .active   (active),
    .wr_n     (wr_n_i),
    .lane_n   (lane_n_i),
    .cyc      (cyc),
    .do_access(do_access),
    .do_write (do_write)
  );

  sram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_req (
    .clk       (clk),
    .rst       (rst),
    .cyc       (cyc),
    .do_access (do_access),
    .do_write  (do_write),
    .addr_i    (addr_i),
    .lane_n    (lane_n_i),
    .wdata_i   (wdata_i),
    .active_o  (active),
    .req_vld_o (req_vld),
    .req_wr_o  (req_wr),
    .req_addr_o(req_addr),
    .req_be_o  (req_be),
    .req_data_o(req_data)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .en    (req_vld && !sleep_i),
    .wr    (req_wr),
    .addr  (req_addr),
    .be    (req_be),
    .wdata (req_data),
    .rdata (rdata_o),
    .rvalid(rvalid)
  );

  assign drive_o = rvalid && !oe_n_i && !sleep_i;
endmodule

// File: rtl/sram_bus_checker.sv
module sram_bus_checker #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_n_i,
  input logic              ce_n_i,
  input logic              wr_n_i,
  input logic [LANES-1:0]  lane_n_i,
  input logic              oe_n_i,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o
);
  logic start, wr_now;
  assign start  = !strobe_n_i && !ce_n_i;
  assign wr_now = !wr_n_i && !(&lane_n_i);

  always_comb begin
    // R8
    if (oe_n_i === 1'b1) oe_gate_chk: assert (drive_o !== 1'b1);
    // R9
    if (sleep_i === 1'b1) sleep_gate_chk: assert (drive_o !== 1'b1);
  end

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_n_i && ce_n_i) |-> ##2 !drive_o);

  // R7
  write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (start && wr_now && !sleep_i) |-> ##2 !drive_o);

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !wr_now && !sleep_i) ##1 !sleep_i |-> ##1 (oe_n_i || sleep_i || drive_o));

  // R4
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !wr_now && !sleep_i) ##1 (strobe_n_i && !wr_now && !sleep_i) ##1 !sleep_i
      |-> ##1 (rdata_o == $past(rdata_o)));
endmodule

bind sync_burst_sram sram_bus_checker #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe_n_i(strobe_n_i),
  .ce_n_i    (ce_n_i),
  .wr_n_i    (wr_n_i),
  .lane_n_i  (lane_n_i),
  .oe_n_i    (oe_n_i),
  .sleep_i   (sleep_i),
  .rdata_o   (rdata_o),
  .drive_o   (drive_o)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 256;
  localparam int AW     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic        ce_n = 1'b1, strobe_n = 1'b0, wr_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  lane_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        drive;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] refm [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .strobe_n_i(strobe_n),
    .lane_n_i(lane_n), .wr_n_i(wr_n), .wdata_i(wdata), .oe_n_i(oe_n),
    .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b, ~b, b ^ 8'h5A, b + 8'd17};
  endfunction

  // deselect cycle with junk write data (R10: later data must not be stored)
  task automatic idle();
    strobe_n = 1'b0; ce_n = 1'b1; wr_n = 1'b1; lane_n = 4'hF;
    wdata = 32'hDEAD_BEEF; addr = 8'hEE;
  endtask

  task automatic wr(input int a, input logic [3:0] ln, input logic [31:0] d, input string req);
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b0; lane_n = ln; addr = AW'(a); wdata = d;
    @(negedge clk); idle(); @(negedge clk);
    for (int i = 0; i < 4; i++) if (!ln[i]) refm[a][i*8 +: 8] = d[i*8 +: 8];
    if (!(&ln)) check(drive == 1'b0, req, {31'd0, drive}, 32'd0);
  endtask

  task automatic rd(input int a, input string req);
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b1; lane_n = 4'hF; addr = AW'(a);
    @(negedge clk); idle(); @(negedge clk);
    check(drive == 1'b1, req, {31'd0, drive}, 32'd1);
    check(rdata == refm[a], req, rdata, refm[a]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check(drive == 1'b0, "R1 during reset", {31'd0, drive}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(drive == 1'b0, "R1 after reset", {31'd0, drive}, 32'd0);

    // R2 R7 R10: full sweep
    for (int a = 0; a < DEPTH; a++) wr(a, 4'h0, pat(a), "R7 write no drive");
    for (int a = 0; a < DEPTH; a++) rd(a, "R2 sweep read");

    // R6 R5: every lane pattern
    for (int m = 0; m < 16; m++) begin
      wr(m * 7 + 3, 4'(m), 32'h1357_9BDF ^ {4{4'(m), 4'(15 - m)}}, "R6 lane write");
      rd(m * 7 + 3, "R6 lane readback");
    end

    // R5: global write enable high with lanes low is a read
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b1; lane_n = 4'h0; addr = 8'd5; wdata = 32'h0BAD_F00D;
    @(negedge clk); idle(); @(negedge clk);
    check(drive == 1'b1, "R5 read decode drives", {31'd0, drive}, 32'd1);
    check(rdata == refm[5], "R5 no write", rdata, refm[5]);
    rd(5, "R5 unchanged");

    // R4: suspended read keeps held address
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b1; lane_n = 4'hF; addr = 8'd10;
    @(negedge clk);
    strobe_n = 1'b1; ce_n = 1'b1; addr = 8'd11;
    @(negedge clk);
    check(rdata == refm[10] && drive, "R4 suspend read 1", rdata, refm[10]);
    @(negedge clk);
    check(rdata == refm[10] && drive, "R4 suspend read 2", rdata, refm[10]);
    idle(); @(negedge clk);

    // R4 R10: suspended write merges lane 0 into held word
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b0; lane_n = 4'h0; addr = 8'd20; wdata = 32'hAABB_CCDD;
    @(negedge clk);
    strobe_n = 1'b1; ce_n = 1'b1; addr = 8'd21; lane_n = 4'b1110; wdata = 32'h1122_3344;
    @(negedge clk); idle(); @(negedge clk);
    refm[20] = 32'hAABB_CC44;
    rd(20, "R4 suspend write merge");
    rd(21, "R4 suspend address ignored");
    rd(20, "R10 data of own edge");

    // R3: after deselect, strobe-high cycles do nothing
    @(negedge clk);
    strobe_n = 1'b1; ce_n = 1'b0; wr_n = 1'b0; lane_n = 4'h0; addr = 8'd30; wdata = 32'h5555_5555;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(drive == 1'b0, "R3 no drive while deselected", {31'd0, drive}, 32'd0);
    end
    strobe_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check(drive == 1'b0, "R3 suspend read deselected", {31'd0, drive}, 32'd0);
    idle(); @(negedge clk);
    rd(20, "R3 held word untouched");
    rd(30, "R3 new address untouched");

    // R8: output enable gating, asynchronous
    oe_n = 1'b1;
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b1; lane_n = 4'hF; addr = 8'd40;
    @(negedge clk); idle(); @(negedge clk);
    check(drive == 1'b0, "R8 oe high blocks", {31'd0, drive}, 32'd0);
    check(rdata == refm[40], "R8 data registered", rdata, refm[40]);
    oe_n = 1'b0; #1;
    check(drive == 1'b1, "R8 oe low drives at once", {31'd0, drive}, 32'd1);
    @(negedge clk);

    // R9: sleep blocks writes and drive
    sleep = 1'b1;
    wr(50, 4'h0, 32'hFFFF_0000, "R9 sleep write");
    refm[50] = pat(50);
    sleep = 1'b0;
    rd(50, "R9 sleep write blocked");
    strobe_n = 1'b0; ce_n = 1'b0; wr_n = 1'b1; lane_n = 4'hF; addr = 8'd51;
    @(negedge clk); idle(); @(negedge clk);
    check(drive == 1'b1, "R9 before sleep", {31'd0, drive}, 32'd1);
    sleep = 1'b1; #1;
    check(drive == 1'b0, "R9 sleep drops drive", {31'd0, drive}, 32'd0);
    sleep = 1'b0; #1;
    check(drive == 1'b1, "R9 wake restores drive", {31'd0, drive}, 32'd1);
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule